// File: doc/BRIEF.md
# LCD Common/Segment Scan Timing Generator

This block turns a free-running display clock into the row scan of a dot-matrix LCD with 32 graphic commons, one icon common and 120 segments. Each frame it steps through the active common lines, asks the display RAM for the row that belongs to the current line, and drives the segment levels from that row. It applies vertical scrolling, row and column mirroring, and three multiplex settings. It also runs an icon-only low-power scan, a frame inversion flag, and a slow square wave that drives four static annunciators and their backplane.

The RAM read is combinational: the block presents a row address and expects the 120-bit row back in the same cycle. The outputs are digital select levels. A separate analog stage turns them into drive voltages using the inversion flag. The mode inputs come from a command register block and are sampled by the display clock.

Top module: `lcd_scan_timing`

## Requirements
- R1: With scroll value s, scanned common c (0..31) reads RAM row (c + s) mod 32 when row mirroring is off. Segment k shows bit k of the returned row when column mirroring is off.
- R2: With row mirroring on (rowFlip=1), scanned common c reads RAM row (31 - c + s) mod 32.
- R3: With column mirroring on (colFlip=1), segment k shows bit 119-k of the returned row.
- R4: Whenever COM32 is selected, the row address is 32 (the icon row), whatever the scroll and mirroring settings.
- R5: muxSel 00 scans 32 lines, 01 scans 16 lines and 1x scans 33 lines. In a frame of L clocks with n lines, k clocks after frame start the scanned line is floor(k*n/L). Line i selects COM i (line 32 selects COM32), and at most one common is selected at a time.
- R6: In the 16-line setting with the display on, COM16..COM31 are flagged on comDummy and are never selected.
- R7: With iconMode=1, only COM32 is scanned and COM0..COM31 are neither selected nor flagged as dummy.
- R8: A frame lasts 576 clocks when fastClk=0 and 768 clocks when fastClk=1. frameM toggles on the clock that ends each frame.
- R9: With dispOn=0, comSel, comDummy and segOut are all zero. Frame and icon timing keep running.
- R10: iconBp is a 50% square wave that toggles every 1024 clocks (period 2048). Each iconOut bit equals iconBp when its iconEn bit is 0 and its inverse when it is 1.
- R11: A change of muxSel, iconMode or fastClk restarts the frame at count 0 on the next clock without toggling frameM.
- R12: During reset, frameM and iconBp are 0, the scan sits at line 0 of a 576-clock frame, and with the display off all select outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispOn | input | 1 | Enables the common and segment outputs |
| muxSel | input | 2 | Multiplex setting: 00 = 32 lines, 01 = 16 lines, 1x = 33 lines |
| iconMode | input | 1 | Icon-only scan of COM32 |
| rowFlip | input | 1 | Mirrors the row-to-common assignment |
| colFlip | input | 1 | Mirrors the column-to-segment assignment |
| scroll | input | 5 | Vertical scroll offset in rows |
| fastClk | input | 1 | Frame length select: 0 = 576 clocks, 1 = 768 clocks |
| iconEn | input | 4 | Per-annunciator on/off |
| ramRowData | input | 120 | Row read back from display RAM for ramRowAddr |
| ramRowAddr | output | 6 | RAM row being displayed (32 = icon row) |
| comSel | output | 33 | One-hot selected common, bit 32 = COM32 |
| comDummy | output | 33 | Commons driven with the dummy non-select pattern |
| segOut | output | 120 | Segment on/off levels for the selected line |
| frameM | output | 1 | Frame inversion flag |
| iconBp | output | 1 | Annunciator backplane square wave |
| iconOut | output | 4 | Annunciator drive waves |

## Verification
The assertions assume the mode inputs change only between clock edges and hold steady across a sampling edge. The icon phase check also assumes that iconEn does not change on the same clock as the backplane. The bench changes every input on the falling clock edge. It alters iconEn only at points far from a backplane toggle, and it changes the mode bits mid-frame on purpose to exercise the restart. A behavioural model in the bench computes the line from the clock count since frame start by one division per cycle. It checks the address, selects, segments and waves against that model on every clock.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int COM_ROWS  = 32;                       // graphic commons, power of two
  localparam int SEG_COLS  = 120;
  localparam int NUM_ICONS = 4;
  localparam int ROW_W     = $clog2(COM_ROWS);
  localparam int LINE_W    = $clog2(COM_ROWS + 1);

  typedef struct packed {
    logic [LINE_W-1:0] line;     // current scan line
    logic              iconOnly; // icon-only scan
    logic              half;     // 16-line setting
    logic              tall;     // 33-line setting
  } scanCtl_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int SLOW_DIV = 576,
  parameter int FAST_DIV = 768,
  parameter int ICON_DIV = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] muxSel,
  input  logic       iconMode,
  input  logic       fastClk,
  output scanCtl_t   scan,
  output logic       frameM,
  output logic       iconBp
);
  localparam int MAX_DIV   = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CNT_W     = $clog2(MAX_DIV);
  localparam int ICON_HALF = ICON_DIV / 2;
  localparam int IC_W      = $clog2(ICON_HALF);

  logic [CNT_W-1:0]  frameLen, nLines, frameCnt, acc;
  logic [CNT_W:0]    accSum;
  logic [LINE_W-1:0] line;
  logic [3:0]        cfg, cfgQ;
  logic [IC_W-1:0]   iconCnt;
  logic              restart, frameEnd;

  assign frameLen = fastClk ? CNT_W'(FAST_DIV) : CNT_W'(SLOW_DIV);

  always_comb begin
    if (iconMode) nLines = CNT_W'(1);
    else begin
      case (muxSel)
        2'b00:   nLines = CNT_W'(COM_ROWS);
        2'b01:   nLines = CNT_W'(COM_ROWS / 2);
        default: nLines = CNT_W'(COM_ROWS + 1);
      endcase
    end
  end

  assign cfg      = {muxSel, iconMode, fastClk};
  assign restart  = (cfg != cfgQ);
  assign frameEnd = (frameCnt == frameLen - CNT_W'(1));
  assign accSum   = {1'b0, acc} + {1'b0, nLines};

  // line advances by Bresenham stepping: exactly nLines steps per frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      frameCnt <= '0;
      acc      <= '0;
      line     <= '0;
      frameM   <= 1'b0;
    end else begin
      cfgQ <= cfg;
      if (restart) begin
        frameCnt <= '0;
        acc      <= '0;
        line     <= '0;
      end else if (frameEnd) begin
        frameCnt <= '0;
        acc      <= '0;
        line     <= '0;
        frameM   <= ~frameM;
      end else begin
        frameCnt <= frameCnt + CNT_W'(1);
        if (accSum >= {1'b0, frameLen}) begin
          acc  <= CNT_W'(accSum - {1'b0, frameLen});
          line <= line + LINE_W'(1);
        end else begin
          acc  <= accSum[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iconCnt <= '0;
      iconBp  <= 1'b0;
    end else if (iconCnt == IC_W'(ICON_HALF - 1)) begin
      iconCnt <= '0;
      iconBp  <= ~iconBp;
    end else begin
      iconCnt <= iconCnt + IC_W'(1);
    end
  end

  assign scan.line     = line;
  assign scan.iconOnly = iconMode;
  assign scan.half     = !iconMode && (muxSel == 2'b01);
  assign scan.tall     = !iconMode && muxSel[1];
endmodule

// File: rtl/lcd_scan_path.sv
module lcd_scan_path
  import lcd_scan_pkg::*;
(
  input  scanCtl_t              scan,
  input  logic                  dispOn,
  input  logic                  rowFlip,
  input  logic                  colFlip,
  input  logic [ROW_W-1:0]      scroll,
  input  logic [SEG_COLS-1:0]   ramRowData,
  input  logic                  iconBp,
  input  logic [NUM_ICONS-1:0]  iconEn,
  output logic [LINE_W-1:0]     ramRowAddr,
  output logic [COM_ROWS:0]     comSel,
  output logic [COM_ROWS:0]     comDummy,
  output logic [SEG_COLS-1:0]   segOut,
  output logic [NUM_ICONS-1:0]  iconOut
);
  logic             onIcon;
  logic [ROW_W-1:0] phys, logical, rowIdx;

  always_comb begin
    onIcon  = scan.iconOnly || (scan.tall && (scan.line == LINE_W'(COM_ROWS)));
    phys    = scan.line[ROW_W-1:0];
    logical = rowFlip ? (ROW_W'(COM_ROWS - 1) - phys) : phys;
    rowIdx  = logical + scroll;   // wraps modulo COM_ROWS
    ramRowAddr = onIcon ? LINE_W'(COM_ROWS) : LINE_W'(rowIdx);
    comSel = '0;
    if (dispOn) begin
      if (onIcon) comSel[COM_ROWS] = 1'b1;
      else        comSel[phys]     = 1'b1;
    end
  end

  for (genvar k = 0; k <= COM_ROWS; k++) begin : g_dummy
    if (k >= COM_ROWS / 2 && k < COM_ROWS) begin : g_low
      assign comDummy[k] = dispOn & scan.half;
    end else begin : g_none
      assign comDummy[k] = 1'b0;
    end
  end

  for (genvar j = 0; j < SEG_COLS; j++) begin : g_seg
    assign segOut[j] = dispOn & (colFlip ? ramRowData[SEG_COLS-1-j] : ramRowData[j]);
  end

  for (genvar i = 0; i < NUM_ICONS; i++) begin : g_icon
    assign iconOut[i] = iconBp ^ iconEn[i];
  end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int SLOW_DIV = 576,
  parameter int FAST_DIV = 768,
  parameter int ICON_DIV = 2048
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dispOn,
  input  logic [1:0]           muxSel,
  input  logic                 iconMode,
  input  logic                 rowFlip,
  input  logic                 colFlip,
  input  logic [ROW_W-1:0]     scroll,
  input  logic                 fastClk,
  input  logic [NUM_ICONS-1:0] iconEn,
  input  logic [SEG_COLS-1:0]  ramRowData,
  output logic [LINE_W-1:0]    ramRowAddr,
  output logic [COM_ROWS:0]    comSel,
  output logic [COM_ROWS:0]    comDummy,
  output logic [SEG_COLS-1:0]  segOut,
  output logic                 frameM,
  output logic                 iconBp,
  output logic [NUM_ICONS-1:0] iconOut
);
  scanCtl_t scan;

  lcd_scan_ctrl #(
    .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .ICON_DIV(ICON_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .muxSel(muxSel), .iconMode(iconMode),
    .fastClk(fastClk), .scan(scan), .frameM(frameM), .iconBp(iconBp)
  );

  lcd_scan_path u_path (
    .scan(scan), .dispOn(dispOn), .rowFlip(rowFlip), .colFlip(colFlip),
    .scroll(scroll), .ramRowData(ramRowData), .iconBp(iconBp), .iconEn(iconEn),
    .ramRowAddr(ramRowAddr), .comSel(comSel), .comDummy(comDummy),
    .segOut(segOut), .iconOut(iconOut)
  );
endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk
  import lcd_scan_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 dispOn,
  input logic                 iconMode,
  input logic [NUM_ICONS-1:0] iconEn,
  input logic [LINE_W-1:0]    ramRowAddr,
  input logic [COM_ROWS:0]    comSel,
  input logic [COM_ROWS:0]    comDummy,
  input logic [SEG_COLS-1:0]  segOut,
  input logic                 frameM,
  input logic                 iconBp,
  input logic [NUM_ICONS-1:0] iconOut
);
  assert_blank_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |-> (comSel == '0 && comDummy == '0 && segOut == '0));

  assert_single_common_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSel));

  assert_icon_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dispOn && iconMode) |-> (comSel == {1'b1, {COM_ROWS{1'b0}}} && comDummy == '0));

  assert_icon_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dispOn && comSel[COM_ROWS]) |-> (ramRowAddr == LINE_W'(COM_ROWS)));

  assert_dummy_disjoint_R6: assert property (@(posedge clk) disable iff (!rstN)
    (comDummy & comSel) == '0);

  assert_frame_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dispOn && !iconMode && (frameM != $past(frameM))) |-> comSel[0]);

  assert_icon_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((iconBp != $past(iconBp)) && $stable(iconEn)) |-> (iconOut == ~$past(iconOut)));
endmodule

bind lcd_scan_timing lcd_scan_timing_chk u_chk (
  .clk(clk), .rstN(rstN), .dispOn(dispOn), .iconMode(iconMode), .iconEn(iconEn),
  .ramRowAddr(ramRowAddr), .comSel(comSel), .comDummy(comDummy), .segOut(segOut),
  .frameM(frameM), .iconBp(iconBp), .iconOut(iconOut)
);

// File: tb/sim_lcd_scan_timing.sv
module sim_lcd_scan_timing;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN, dispOn, iconMode, rowFlip, colFlip, fastClk;
  logic [1:0]   muxSel;
  logic [4:0]   scroll;
  logic [3:0]   iconEn;
  logic [119:0] ramRowData;
  logic [5:0]   ramRowAddr;
  logic [32:0]  comSel, comDummy;
  logic [119:0] segOut;
  logic         frameM, iconBp;
  logic [3:0]   iconOut;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  checking = 0;
  bit  done = 0;

  int  mCnt, mIc, mPrevCfg;
  bit  mM, mBp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timing u0 (
    .clk(clk), .rstN(rstN), .dispOn(dispOn), .muxSel(muxSel), .iconMode(iconMode),
    .rowFlip(rowFlip), .colFlip(colFlip), .scroll(scroll), .fastClk(fastClk),
    .iconEn(iconEn), .ramRowData(ramRowData), .ramRowAddr(ramRowAddr),
    .comSel(comSel), .comDummy(comDummy), .segOut(segOut), .frameM(frameM),
    .iconBp(iconBp), .iconOut(iconOut)
  );

  function automatic logic [119:0] rowPattern(int a);
    logic [119:0] r;
    for (int j = 0; j < 120; j++) r[j] = (((j * (a + 3) + a) % 7) < 3);
    return r;
  endfunction

  always_comb ramRowData = rowPattern(int'(ramRowAddr));

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int n, L, line, phys, logical, row, addr;
    bit onIcon;
    logic [32:0]  expCom, expDummy;
    logic [119:0] pat, expSeg;
    L = fastClk ? 768 : 576;
    n = iconMode ? 1 : (muxSel == 2'b00 ? 32 : (muxSel == 2'b01 ? 16 : 33));
    line = (mCnt * n) / L;
    onIcon = iconMode || (n == 33 && line == 32);
    phys = line % 32;
    logical = rowFlip ? 31 - phys : phys;
    row = (logical + int'(scroll)) % 32;
    addr = onIcon ? 32 : row;
    expCom = '0;
    expDummy = '0;
    if (dispOn) expCom[onIcon ? 32 : phys] = 1'b1;
    if (dispOn && !iconMode && muxSel == 2'b01)
      for (int k = 16; k < 32; k++) expDummy[k] = 1'b1;
    pat = rowPattern(addr);
    for (int j = 0; j < 120; j++)
      expSeg[j] = dispOn & (colFlip ? pat[119-j] : pat[j]);
    check(onIcon ? "R4 row address" : (rowFlip ? "R2 row address" : "R1 row address"),
          128'(ramRowAddr), 128'(addr));
    check(!dispOn ? "R9 commons" : (iconMode ? "R7 commons" : "R5 commons"),
          128'(comSel), 128'(expCom));
    check(!dispOn ? "R9 dummy" : "R6 dummy", 128'(comDummy), 128'(expDummy));
    check(!dispOn ? "R9 segments" : (colFlip ? "R3 segments" : "R1 segments"),
          128'(segOut), 128'(expSeg));
    check("R8 frameM", 128'(frameM), 128'(mM));
    check("R10 backplane", 128'(iconBp), 128'(mBp));
    check("R10 icons", 128'({4{mBp}} ^ iconEn), 128'(iconOut));
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    int cfg, L;
    if (!rstN) begin
      mCnt = 0; mIc = 0; mM = 0; mBp = 0; mPrevCfg = 0;
    end else begin
      cfg = {muxSel, iconMode, fastClk};
      L = fastClk ? 768 : 576;
      if (cfg != mPrevCfg) mCnt = 0;                 // R11
      else if (mCnt == L - 1) begin mCnt = 0; mM = !mM; end
      else mCnt++;
      mPrevCfg = cfg;
      if (mIc == 1023) begin mIc = 0; mBp = !mBp; end else mIc++;
    end
    #(CLK_PERIOD/4);
    if (checking && !done) compareAll();
  end

  task automatic runCycles(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; dispOn = 0; muxSel = 2'b00; iconMode = 0; rowFlip = 0;
    colFlip = 0; scroll = 0; fastClk = 0; iconEn = 4'b0000;
    runCycles(3);
    // R12: reset state
    check("R12 frameM", 128'(frameM), 128'(0));
    check("R12 iconBp", 128'(iconBp), 128'(0));
    check("R12 commons", 128'(comSel), 128'(0));
    check("R12 segments", 128'(segOut), 128'(0));
    check("R12 row address", 128'(ramRowAddr), 128'(0));
    rstN = 1;
    checking = 1;
    dispOn = 1;
    runCycles(2 * 576 + 10);       // R1 R5 R8 plain scan
    scroll = 5'd5;      runCycles(600);   // R1 scroll
    rowFlip = 1;        runCycles(600);   // R2
    colFlip = 1;        runCycles(600);   // R3
    muxSel = 2'b10; fastClk = 1; scroll = 5'd31;
    runCycles(1600);                      // R4 R5 R8 33 lines, long frame
    runCycles(300);
    muxSel = 2'b00;                       // R11 mid-frame restart
    @(negedge clk);
    check("R11 restart line 0", 128'(comSel), 128'(33'h1));
    runCycles(900);
    muxSel = 2'b01; rowFlip = 0; runCycles(800);   // R6
    iconMode = 1;   runCycles(800);               // R7
    iconEn = 4'b1010; runCycles(3000);            // R10
    dispOn = 0; iconEn = 4'b0110; runCycles(2500); // R9
    iconMode = 0; fastClk = 0; runCycles(1300);   // R9 graphic mode off
    finishRun();
  end
endmodule